// File: doc/BRIEF.md
# Virtual Channel Burst Transfer Sequencer

This block moves data for time-division-multiplexed virtual channels between per-channel internal buffers and buffers in system memory. Each channel runs in one of two directions. A push channel collects serial stream data and needs an outbound burst once its internal buffer is full. A pull channel feeds the serial stream and needs an inbound burst once its internal buffer has run empty. When one or more channels need service, a round-robin arbiter picks one. The block then runs a three-phase bus transaction for it. First it reads the channel's two-word descriptor. Next it moves a fixed-length data burst. Last it writes back the descriptor word that holds the transfer pointer.

Each descriptor is 8 bytes and sits at the table base address plus eight times the channel index. Word 0 holds the external buffer page in bits [31:12] and the last valid offset in bits [11:0]. Word 1 holds the transfer offset in bits [11:0], a wrap toggle in bit 12, and other fields in bits [31:13] that pass through unchanged. The table base is loaded through a write strobe. No channel is served until the base has been loaded at least once. A bus error on any beat abandons the transfer and raises that channel's error flag.

Top module: `vc_burst_seq`

## Requirements
- R1: During and right after reset, bus_req_o, bus_rd_o, bus_wr_o, done_o, buf_pop_o, buf_push_o and all bits of err_o are 0.
- R2: Until base_wr_i has been sampled high once, the block issues no bus request, whatever the channel buffer levels are.
- R3: Channel i needs service when ch_push_i[i]=1 and buf_full_i[i]=1, or when ch_push_i[i]=0 and buf_empty_i[i]=1. A pull channel whose buffer is only full, or a push channel whose buffer is only empty, is never served.
- R4: A transfer for channel c issues, in order: a read at base+8c, a read at base+8c+4, BURST_LEN data beats, and one write at base+8c+4. bus_req_o rises in the cycle after the idle cycle in which the need was sampled.
- R5: Data beat k (k=0..BURST_LEN-1) uses address {word0[31:12], word1[11:0]} + 4k.
- R6: For a push channel, the data beats are writes whose bus_wdata_o equals buf_rdata_i, and each accepted beat pulses buf_pop_o. For a pull channel, the beats are reads, and each accepted beat pulses buf_push_o with buf_wdata_o = bus_rdata_i. bus_rd_o and bus_wr_o are never high together, and one of them is high exactly when bus_req_o is high.
- R7: The write-back value is word 1 with its offset advanced by 4*BURST_LEN. If the advanced offset exceeds word0[11:0], the offset becomes 0 and bit 12 is inverted. Bits [31:13] are unchanged.
- R8: Arbitration is round-robin. The next channel served is the first requesting channel after the last served one, in cyclic index order. After reset the search starts at channel 0.
- R9: A beat accepted with bus_err_i=1 ends the transfer. bus_req_o is low in the next cycle, no further beat of that transfer is issued, and err_o[c] is set from the next cycle.
- R10: done_o pulses for exactly one cycle after the write-back beat is accepted without error, and err_o[c] for that channel clears at the same time.
- R11: A beat completes only in a cycle with bus_req_o and bus_gnt_i both high. Until then, the address and the strobes hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_wr_i | input | 1 | Load strobe for the descriptor table base |
| base_addr_i | input | AW | Descriptor table base address |
| ch_push_i | input | NUM_CH | Per-channel direction, 1 = push |
| buf_full_i | input | NUM_CH | Per-channel internal buffer full |
| buf_empty_i | input | NUM_CH | Per-channel internal buffer empty |
| buf_rdata_i | input | DW | Data from the selected channel's internal buffer |
| buf_pop_o | output | 1 | Consume one word from the internal buffer |
| buf_push_o | output | 1 | Store buf_wdata_o into the internal buffer |
| buf_wdata_o | output | DW | Data for the internal buffer |
| sel_ch_o | output | CH_W | Channel being served |
| bus_req_o | output | 1 | Bus beat request |
| bus_rd_o | output | 1 | Beat is a read |
| bus_wr_o | output | 1 | Beat is a write |
| bus_addr_o | output | AW | Beat address |
| bus_wdata_o | output | DW | Beat write data |
| bus_gnt_i | input | 1 | Beat accepted this cycle |
| bus_err_i | input | 1 | Accepted beat failed |
| bus_rdata_i | input | DW | Read data, valid with bus_gnt_i |
| err_o | output | NUM_CH | Sticky per-channel error flags |
| done_o | output | 1 | Transfer completed |

## Verification
The request, address and strobes of a beat are due one clock edge after the previous beat was granted, or after the idle cycle in which a need was sampled. Buffer pop and push strobes, and the buffer write data, follow the grant in the same cycle. The error flags and the done pulse appear one edge after the deciding beat. The bench drives grant, error and read data just after the falling edge and compares all outputs a moment later against a behavioural model that was advanced on the rising edge, so every expected value is checked in the cycle it is due. Grants are withheld on a fixed pattern to exercise stalls. Descriptor write-backs and the order in which channels are served are also checked against hand-computed values.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRD0,
    ST_DRD1,
    ST_DATA,
    ST_WB
  } vc_state_e;
endpackage

// File: rtl/vc_rr_arb.sv
module vc_rr_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          take_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] last_q;

  // scan from farthest to nearest so the nearest requester wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N; k >= 1; k--) begin
      int c;
      c = int'(last_q) + k;
      if (c >= N) c = c - N;
      if (req_i[c]) begin
        any_o = 1'b1;
        idx_o = IW'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= IW'(N - 1);
    else if (take_i) last_q <= idx_o;
  end
endmodule

// File: rtl/vc_desc_upd.sv
module vc_desc_upd #(
  parameter int STEP = 16
) (
  input  logic [31:0] w0_i,
  input  logic [31:0] w1_i,
  output logic [31:0] w1_o
);
  logic [12:0] nxt;

  always_comb begin
    nxt = {1'b0, w1_i[11:0]} + 13'(STEP);
    if (nxt > {1'b0, w0_i[11:0]}) w1_o = {w1_i[31:13], ~w1_i[12], 12'h000};
    else                          w1_o = {w1_i[31:12], nxt[11:0]};
  end
endmodule

// File: rtl/vc_burst_seq.sv
module vc_burst_seq #(
  parameter int NUM_CH    = 4,
  parameter int BURST_LEN = 4,
  parameter int AW        = 32,
  parameter int DW        = 32,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BT_W     = $clog2(BURST_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_wr_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic [NUM_CH-1:0] ch_push_i,
  input  logic [NUM_CH-1:0] buf_full_i,
  input  logic [NUM_CH-1:0] buf_empty_i,
  input  logic [DW-1:0]     buf_rdata_i,
  output logic              buf_pop_o,
  output logic              buf_push_o,
  output logic [DW-1:0]     buf_wdata_o,
  output logic [CH_W-1:0]   sel_ch_o,
  output logic              bus_req_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic              bus_gnt_i,
  input  logic              bus_err_i,
  input  logic [DW-1:0]     bus_rdata_i,
  output logic [NUM_CH-1:0] err_o,
  output logic              done_o
);
  import vc_pkg::*;

  localparam int STEP = BURST_LEN * 4;

  vc_state_e         state_q;
  logic [CH_W-1:0]   ch_q;
  logic [31:0]       w0_q, w1_q, w1_upd;
  logic [BT_W-1:0]   beat_q;
  logic [NUM_CH-1:0] err_q;
  logic              done_q;
  logic [AW-1:0]     base_q;
  logic              base_set_q;

  logic [NUM_CH-1:0] need;
  logic              any_need, take, push_cur, beat_ok, beat_bad;
  logic [CH_W-1:0]   pick;
  logic [AW-1:0]     desc_addr, data_addr;

  assign need     = (ch_push_i & buf_full_i) | (~ch_push_i & buf_empty_i);
  assign take     = (state_q == ST_IDLE) && base_set_q && any_need;
  assign push_cur = ch_push_i[ch_q];
  assign beat_ok  = bus_req_o && bus_gnt_i && !bus_err_i;
  assign beat_bad = bus_req_o && bus_gnt_i && bus_err_i;

  vc_rr_arb #(.N(NUM_CH), .IW(CH_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (need),
    .take_i (take),
    .any_o  (any_need),
    .idx_o  (pick)
  );

  vc_desc_upd #(.STEP(STEP)) u_upd (
    .w0_i (w0_q),
    .w1_i (w1_q),
    .w1_o (w1_upd)
  );

  assign desc_addr = base_q + AW'({ch_q, 3'b000});
  assign data_addr = AW'({w0_q[31:12], w1_q[11:0]}) + AW'({beat_q, 2'b00});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ch_q       <= '0;
      w0_q       <= '0;
      w1_q       <= '0;
      beat_q     <= '0;
      err_q      <= '0;
      done_q     <= 1'b0;
      base_q     <= '0;
      base_set_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (base_wr_i) begin
        base_q     <= base_addr_i;
        base_set_q <= 1'b1;
      end
      if (beat_bad) begin
        err_q[ch_q] <= 1'b1;
        state_q     <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (take) begin
            ch_q    <= pick;
            state_q <= ST_DRD0;
          end
          ST_DRD0: if (beat_ok) begin
            w0_q    <= bus_rdata_i;
            state_q <= ST_DRD1;
          end
          ST_DRD1: if (beat_ok) begin
            w1_q    <= bus_rdata_i;
            beat_q  <= '0;
            state_q <= ST_DATA;
          end
          ST_DATA: if (beat_ok) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == BT_W'(BURST_LEN - 1)) state_q <= ST_WB;
          end
          ST_WB: if (beat_ok) begin
            err_q[ch_q] <= 1'b0;
            done_q      <= 1'b1;
            state_q     <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    unique case (state_q)
      ST_DRD0: bus_addr_o = desc_addr;
      ST_DRD1: bus_addr_o = desc_addr + AW'(4);
      ST_DATA: begin
        bus_addr_o = data_addr;
        if (push_cur) bus_wdata_o = buf_rdata_i;
      end
      ST_WB: begin
        bus_addr_o  = desc_addr + AW'(4);
        bus_wdata_o = DW'(w1_upd);
      end
      default: ;
    endcase
  end

  assign bus_req_o   = (state_q != ST_IDLE);
  assign bus_rd_o    = (state_q == ST_DRD0) || (state_q == ST_DRD1) ||
                       ((state_q == ST_DATA) && !push_cur);
  assign bus_wr_o    = (state_q == ST_WB) || ((state_q == ST_DATA) && push_cur);
  assign buf_pop_o   = (state_q == ST_DATA) && push_cur && beat_ok;
  assign buf_push_o  = (state_q == ST_DATA) && !push_cur && beat_ok;
  assign buf_wdata_o = bus_rdata_i;
  assign sel_ch_o    = ch_q;
  assign err_o       = err_q;
  assign done_o      = done_q;
endmodule

// File: rtl/vc_burst_seq_chk.sv
module vc_burst_seq_chk #(
  parameter int NUM_CH = 4,
  parameter int AW     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              base_set_i,
  input logic              bus_req_o,
  input logic              bus_rd_o,
  input logic              bus_wr_o,
  input logic [AW-1:0]     bus_addr_o,
  input logic              bus_gnt_i,
  input logic              bus_err_i,
  input logic              buf_pop_o,
  input logic              buf_push_o,
  input logic [NUM_CH-1:0] err_o,
  input logic              done_o
);
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o) &&
                                $stable(bus_rd_o) && $stable(bus_wr_o));
  // R2
  no_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !base_set_i |-> !bus_req_o);
  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o) && ((bus_rd_o || bus_wr_o) == bus_req_o));
  // R6
  pop_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_pop_o |-> bus_wr_o && bus_gnt_i && !bus_err_i);
  // R6
  buf_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf_pop_o && buf_push_o));
  // R9
  err_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i && bus_err_i |=> !bus_req_o && (err_o != '0));
  // R10
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_req_o && bus_gnt_i && !bus_err_i && bus_wr_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind vc_burst_seq vc_burst_seq_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .base_set_i (base_set_q),
  .bus_req_o  (bus_req_o),
  .bus_rd_o   (bus_rd_o),
  .bus_wr_o   (bus_wr_o),
  .bus_addr_o (bus_addr_o),
  .bus_gnt_i  (bus_gnt_i),
  .bus_err_i  (bus_err_i),
  .buf_pop_o  (buf_pop_o),
  .buf_push_o (buf_push_o),
  .err_o      (err_o),
  .done_o     (done_o)
);

// File: tb/vc_burst_seq_test.sv
module vc_burst_seq_test;
  localparam int N  = 4;
  localparam int BL = 4;

  logic        clk = 0, rst_n = 0;
  logic        base_wr = 0;
  logic [31:0] base_addr = 0;
  logic [N-1:0] ch_push = 0, buf_full = 0, buf_empty = 0;
  logic [31:0] buf_rdata = 0, bus_rdata = 0;
  logic        bus_gnt = 0, bus_err = 0;
  logic        buf_pop, buf_push, bus_req, bus_rd, bus_wr, done;
  logic [31:0] buf_wdata, bus_addr, bus_wdata;
  logic [1:0]  sel_ch;
  logic [N-1:0] err;

  vc_burst_seq #(.NUM_CH(N), .BURST_LEN(BL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .base_wr_i(base_wr), .base_addr_i(base_addr),
    .ch_push_i(ch_push), .buf_full_i(buf_full), .buf_empty_i(buf_empty),
    .buf_rdata_i(buf_rdata), .buf_pop_o(buf_pop), .buf_push_o(buf_push),
    .buf_wdata_o(buf_wdata), .sel_ch_o(sel_ch), .bus_req_o(bus_req),
    .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_gnt_i(bus_gnt), .bus_err_i(bus_err),
    .bus_rdata_i(bus_rdata), .err_o(err), .done_o(done)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];
  int served_q[$];
  logic [31:0] wb_q[$];
  bit inject_err = 0;
  bit saw_req = 0;

  // behavioural model state
  int m_phase, m_ch, m_last, m_beat;
  logic [31:0] m_w0, m_w1, m_base;
  logic [N-1:0] m_err;
  bit m_done, m_bset;

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] upd(input logic [31:0] w0, input logic [31:0] w1);
    int nxt;
    nxt = int'(w1[11:0]) + 4 * BL;
    if (nxt > int'(w0[11:0])) return {w1[31:13], ~w1[12], 12'h000};
    return {w1[31:12], 12'(nxt)};
  endfunction

  function automatic logic [31:0] rd_val(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] m_desc();
    return m_base + 32'(m_ch * 8);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_ch = 0; m_last = N - 1; m_beat = 0;
      m_w0 = 0; m_w1 = 0; m_base = 0; m_err = 0; m_done = 0; m_bset = 0;
    end else begin
      m_done = 0;
      if (bus_gnt && bus_err && m_phase != 0) begin
        m_err[m_ch] = 1'b1;
        m_phase = 0;
      end else begin
        case (m_phase)
          0: if (m_bset) begin
            for (int k = 1; k <= N; k++) begin
              int c;
              c = (m_last + k) % N;
              if (m_phase == 0 && (ch_push[c] ? buf_full[c] : buf_empty[c])) begin
                m_ch = c; m_last = c; m_phase = 1;
              end
            end
          end
          1: if (bus_gnt) begin m_w0 = bus_rdata; m_phase = 2; end
          2: if (bus_gnt) begin m_w1 = bus_rdata; m_beat = 0; m_phase = 3; end
          3: if (bus_gnt) begin
            m_beat++;
            if (m_beat == BL) m_phase = 4;
          end
          4: if (bus_gnt) begin
            mem[m_desc() + 4] = upd(m_w0, m_w1);
            m_err[m_ch] = 1'b0;
            m_done = 1;
            m_phase = 0;
          end
          default: m_phase = 0;
        endcase
      end
      if (base_wr) begin m_base = base_addr; m_bset = 1; end
    end
  end

  // drive bus slave after the falling edge, then compare
  always @(negedge clk) begin
    cyc++;
    bus_gnt = (cyc % 4) != 3;
    bus_err = 0;
    if (inject_err && bus_gnt && m_phase == 3) begin
      bus_err = 1;
      inject_err = 0;
    end
    bus_rdata = rd_val(bus_addr);
    buf_rdata = 32'hD000_0000 + 32'(cyc);
    #1;
    if (rst_n) begin
      bit er, ew, pushd;
      logic [31:0] ea;
      pushd = (m_phase != 0) && ch_push[m_ch];
      er = (m_phase == 1) || (m_phase == 2) || (m_phase == 3 && !pushd);
      ew = (m_phase == 4) || (m_phase == 3 && pushd);
      if (bus_req) saw_req = 1;
      check(bus_req === (m_phase != 0), "R4 req", 32'(bus_req), 32'(m_phase != 0));
      if (m_phase != 0) begin
        case (m_phase)
          1: ea = m_desc();
          3: ea = {m_w0[31:12], m_w1[11:0]} + 32'(4 * m_beat);
          default: ea = m_desc() + 4;
        endcase
        check(bus_addr === ea, m_phase == 3 ? "R5 addr" : "R4 addr", bus_addr, ea);
        check(bus_rd === er && bus_wr === ew, "R6 strobes", {bus_rd, bus_wr}, {er, ew});
        check(sel_ch === 2'(m_ch), "R8 channel", 32'(sel_ch), 32'(m_ch));
        if (m_phase == 4)
          check(bus_wdata === upd(m_w0, m_w1), "R7 writeback", bus_wdata, upd(m_w0, m_w1));
        else if (ew)
          check(bus_wdata === buf_rdata, "R6 push data", bus_wdata, buf_rdata);
        if (m_phase == 4 && bus_gnt && !bus_err) wb_q.push_back(bus_wdata);
      end
      check(buf_pop === (m_phase == 3 && pushd && bus_gnt && !bus_err), "R6 pop",
            32'(buf_pop), 32'(m_phase == 3 && pushd && bus_gnt && !bus_err));
      check(buf_push === (m_phase == 3 && !pushd && bus_gnt && !bus_err), "R6 push",
            32'(buf_push), 32'(m_phase == 3 && !pushd && bus_gnt && !bus_err));
      if (buf_push) check(buf_wdata === bus_rdata, "R6 buf data", buf_wdata, bus_rdata);
      check(err === m_err, "R9 err flags", 32'(err), 32'(m_err));
      check(done === m_done, "R10 done", 32'(done), 32'(m_done));
      if (done) served_q.push_back(int'(sel_ch));
    end
  end

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic finish_tb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog act=hang exp=completion");
    finish_tb();
  end

  initial begin
    for (int c = 0; c < N; c++) begin
      mem[32'h0001_0000 + 32'(c * 8)]     = 32'h0030_003C + 32'(c << 20);
      mem[32'h0001_0000 + 32'(c * 8) + 4] = 32'h1234_0000;
    end
    mem[32'h0001_0010] = 32'h0020_001F;
    mem[32'h0001_0014] = 32'hABCD_E000;

    repeat (3) tick();
    // R1
    check(!bus_req && !bus_rd && !bus_wr && !done && !buf_pop && !buf_push && err == 0,
          "R1 reset state", {bus_req, bus_rd, bus_wr, done, err}, 32'h0);
    rst_n = 1;
    tick();
    check(!bus_req && err == 0 && !done, "R1 after release", {bus_req, err, done}, 32'h0);

    // R2: needs present but no base loaded
    ch_push = 4'b0100; buf_full = 4'b0100; buf_empty = 4'b0001;
    repeat (30) tick();
    check(!saw_req, "R2 no base", 32'(saw_req), 32'h0);

    buf_full = 0; buf_empty = 0;
    base_addr = 32'h0001_0000; base_wr = 1;
    tick();
    base_wr = 0;

    // R7: single push channel, offset advance then wrap
    buf_full = 4'b0100;
    while (served_q.size() < 2) tick();
    buf_full = 0;
    check(wb_q[0] === 32'hABCD_E010, "R7 advance", wb_q[0], 32'hABCD_E010);
    check(wb_q[1] === 32'hABCD_F000, "R7 wrap toggle", wb_q[1], 32'hABCD_F000);
    check(served_q[0] == 2 && served_q[1] == 2, "R4 served", 32'(served_q[0]), 32'h2);
    repeat (5) tick();
    served_q.delete(); wb_q.delete();

    // R8 / R3: ch0 pull empty, ch2 push full, ch3 pull but only full
    buf_full = 4'b1100; buf_empty = 4'b0001;
    while (served_q.size() < 3) tick();
    buf_full = 0; buf_empty = 0;
    check(served_q[0] == 0, "R8 first", 32'(served_q[0]), 32'h0);
    check(served_q[1] == 2, "R8 second", 32'(served_q[1]), 32'h2);
    check(served_q[2] == 0, "R8 third", 32'(served_q[2]), 32'h0);
    begin
      int n3 = 0;
      foreach (served_q[i]) if (served_q[i] == 3) n3++;
      check(n3 == 0, "R3 ch3 ignored", 32'(n3), 32'h0);
    end
    repeat (5) tick();
    check(!bus_req, "R3 idle without need", 32'(bus_req), 32'h0);
    served_q.delete();

    // R9 / R10: error mid-burst, then recovery
    buf_full = 4'b0100;
    inject_err = 1;
    while (err == 0) tick();
    check(err === 4'b0100, "R9 flag set", 32'(err), 32'h4);
    check(served_q.size() == 0, "R9 no completion", 32'(served_q.size()), 32'h0);
    while (served_q.size() < 1) tick();
    buf_full = 0;
    check(served_q[0] == 2, "R10 retry channel", 32'(served_q[0]), 32'h2);
    check(err === 4'b0000, "R10 flag cleared", 32'(err), 32'h0);
    repeat (8) tick();
    finish_tb();
  end
endmodule